// File: doc/BRIEF.md
# Local Interrupt Priority Selector

This block picks which of seven local interrupts a hart should take next, and in which privilege mode the trap lands. Each cycle it looks at the pending and enable vectors, a delegation mask and one enable per destination mode. Those seven sources are the machine external, software and timer interrupts, the supervisor external, software and timer interrupts, and the local counter-overflow interrupt.

Supervisor-class sources whose delegation bit is set are routed to supervisor mode. Every other source is routed to machine mode. A candidate bound for machine mode always wins over one bound for supervisor mode. Inside one destination, a fixed rank applies, and the counter-overflow source sits at the very bottom of it.

The winner's cause code and destination are captured in an output register. The surrounding trap logic therefore sees a stable request one cycle after the inputs move. The output register is a three-state machine:

- DST_NONE: nothing to take.
- DST_S: take the interrupt into supervisor mode.
- DST_M: take the interrupt into machine mode.

Three transitions lead out of any state on every clock:

- GO_M: a machine-bound candidate exists.
- GO_S: no machine-bound candidate exists, but a supervisor-bound one does.
- GO_IDLE: no candidate exists.

Top module: `irq_prio_sel`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `take_vld` is 0, `take_cause` is 0 and `take_mode` is 2'b00, whatever the inputs hold.
- R2: A source is a candidate only when both its pending bit and its enable bit are 1. A pending bit without its enable bit, or an enable bit without its pending bit, yields no request.
- R3: If any machine-bound candidate exists, the result targets machine mode, even when a supervisor-bound candidate of higher rank is present.
- R4: Among machine-bound candidates the winner follows this rank, highest first: cause 11, 3, 7, 9, 1, 5, 13.
- R5: Among supervisor-bound candidates the winner follows this rank, highest first: cause 9, 1, 5, 13. Each of these is reported with `take_mode` = 2'b01.
- R6: Delegation bits at positions 11, 3 and 7 have no effect. Those sources always target machine mode.
- R7: The counter-overflow source uses bit 13 of the pending, enable and delegation vectors and reports cause 13. Its delegation bit alone decides whether it goes to S or M.
- R8: Bit positions outside the implemented mask (default: 1, 3, 5, 7, 9, 11, 13) never produce a request, even when pending and enabled.
- R9: `m_en` = 0 removes all machine-bound candidates. `s_en` = 0 removes all supervisor-bound candidates. Each one leaves the other destination's arbitration unchanged.
- R10: Outputs change exactly one clock edge after the inputs that cause the change, and hold their values between edges.
- R11: Encodings: `take_cause` is the 4-bit bit position of the winner. `take_mode` is 2'b11 for machine, 2'b01 for supervisor and 2'b00 when `take_vld` is 0, in which case `take_cause` is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | IRQ_W (16) | Pending bits, indexed by cause code |
| irq_en | input | IRQ_W (16) | Enable bits, indexed by cause code |
| irq_deleg | input | IRQ_W (16) | Delegation mask; 1 routes a supervisor-class source to S mode |
| m_en | input | 1 | Enable for machine-bound interrupts |
| s_en | input | 1 | Enable for supervisor-bound interrupts |
| take_vld | output | 1 | An interrupt is selected |
| take_cause | output | CAUSE_W (4) | Cause code of the selected interrupt |
| take_mode | output | 2 | Destination mode: 11 = M, 01 = S, 00 = none |

## Verification
Every result of this block comes out of a single output register. A change on the inputs is therefore due on the first rising edge after the change, and not before it.

The bench drives each new input pattern 1 ns after a rising edge. It then waits for the next rising edge and samples 1 ns later, so each check sees exactly one register stage of delay.

The latency scenario also samples before that edge, to confirm that the previous result is still held. The reset scenario samples while reset is asserted with every source pending and enabled.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

    // Number of arbitrated sources and their cause codes in rank order.
    localparam int unsigned N_SRC = 7;

    localparam int unsigned SRC_BIT [N_SRC] = '{11, 3, 7, 9, 1, 5, 13};

    // 1 where the delegation mask can send the source to supervisor mode.
    localparam bit SRC_DELEGABLE [N_SRC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

    // Output-register state doubles as the destination-mode encoding.
    typedef enum logic [1:0] {
        DST_NONE = 2'b00,
        DST_S    = 2'b01,
        DST_M    = 2'b11
    } dest_e;

endpackage

// File: rtl/irqsel_route.sv
module irqsel_route
    import irqsel_pkg::*;
#(
    parameter int unsigned        IRQ_W     = 16,
    parameter logic [IRQ_W-1:0]   IMPL_MASK = 16'h2AAA
) (
    input  logic [IRQ_W-1:0]  irq_pend,
    input  logic [IRQ_W-1:0]  irq_en,
    input  logic [IRQ_W-1:0]  irq_deleg,
    input  logic              m_en,
    input  logic              s_en,
    output logic [N_SRC-1:0]  m_req,
    output logic [N_SRC-1:0]  s_req
);

    // Each source lands in exactly one destination's request vector.
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        localparam int unsigned B = SRC_BIT[g];
        logic active;
        logic to_s;

        assign active = irq_pend[B] & irq_en[B] & IMPL_MASK[B];

        if (SRC_DELEGABLE[g]) begin : g_deleg
            assign to_s = irq_deleg[B];
        end else begin : g_fixed
            assign to_s = 1'b0;
        end

        assign m_req[g] = active & ~to_s & m_en;
        assign s_req[g] = active &  to_s & s_en;
    end

    // Bit positions that carry no source are consumed here on purpose.
    logic unused_vec_bits;
    assign unused_vec_bits = ^{irq_pend, irq_en, irq_deleg};

endmodule

// File: rtl/irqsel_pick.sv
module irqsel_pick #(
    parameter int unsigned N = 7
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         hit
);

    // Index 0 has the highest rank.
    always_comb begin
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    assign hit = |req;

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irqsel_pkg::*;
#(
    parameter int unsigned        IRQ_W     = 16,
    parameter logic [IRQ_W-1:0]   IMPL_MASK = 16'h2AAA,
    localparam int unsigned       CAUSE_W   = $clog2(IRQ_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IRQ_W-1:0]    irq_pend,
    input  logic [IRQ_W-1:0]    irq_en,
    input  logic [IRQ_W-1:0]    irq_deleg,
    input  logic                m_en,
    input  logic                s_en,
    output logic                take_vld,
    output logic [CAUSE_W-1:0]  take_cause,
    output logic [1:0]          take_mode
);

    logic [N_SRC-1:0] m_req, s_req;
    logic [N_SRC-1:0] m_grant, s_grant;
    logic             m_hit, s_hit;

    irqsel_route #(
        .IRQ_W     (IRQ_W),
        .IMPL_MASK (IMPL_MASK)
    ) u_route (
        .irq_pend  (irq_pend),
        .irq_en    (irq_en),
        .irq_deleg (irq_deleg),
        .m_en      (m_en),
        .s_en      (s_en),
        .m_req     (m_req),
        .s_req     (s_req)
    );

    irqsel_pick #(.N(N_SRC)) u_pick_m (
        .req   (m_req),
        .grant (m_grant),
        .hit   (m_hit)
    );

    irqsel_pick #(.N(N_SRC)) u_pick_s (
        .req   (s_req),
        .grant (s_grant),
        .hit   (s_hit)
    );

    dest_e               state_q, state_d;
    logic [CAUSE_W-1:0]  cause_q, cause_d;

    // Next-state: GO_M, GO_S or GO_IDLE from any state.
    always_comb begin
        state_d = DST_NONE;
        unique casez ({m_hit, s_hit})
            2'b1?:   state_d = DST_M;
            2'b01:   state_d = DST_S;
            2'b00:   state_d = DST_NONE;
            default: state_d = DST_NONE;
        endcase
    end

    // Cause of the winner in the chosen destination.
    always_comb begin
        cause_d = '0;
        for (int g = 0; g < N_SRC; g++) begin
            if (state_d == DST_M && m_grant[g]) cause_d = CAUSE_W'(SRC_BIT[g]);
            if (state_d == DST_S && s_grant[g]) cause_d = CAUSE_W'(SRC_BIT[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DST_NONE;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        take_vld   = (state_q != DST_NONE);
        take_mode  = state_q;
        take_cause = cause_q;
    end

    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !take_vld |-> (take_cause == '0 && take_mode == 2'b00)); // R11

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pend & irq_en & IMPL_MASK) == '0) |=> !take_vld); // R2

    AST_M_OVER_S: assert property (@(posedge clk) disable iff (!rst_n)
        m_hit |=> (take_mode == 2'b11)); // R3

    AST_S_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_hit && s_hit) |=> (take_mode == 2'b01)); // R5

    AST_FIXED_M_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vld && (take_cause == 4'd11 || take_cause == 4'd3 || take_cause == 4'd7))
            |-> take_mode == 2'b11); // R6

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_grant) && $onehot0(s_grant)); // R4

    AST_LCOFI_TO_M: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend[13] && irq_en[13] && IMPL_MASK[13] && !irq_deleg[13] && m_en)
            |=> (take_vld && take_mode == 2'b11)); // R7

endmodule

// File: tb/irq_prio_sel_bench.sv
`timescale 1ns/1ps
module irq_prio_sel_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pend = '0, en = '0, deleg = '0;
    logic        men = 1'b1, sen = 1'b1;
    logic        take_vld;
    logic [3:0]  take_cause;
    logic [1:0]  take_mode;

    int n_run = 0;
    int n_fail = 0;

    localparam logic [15:0] ALL_IMPL = 16'h2AAA;
    localparam logic [1:0]  MODE_M = 2'b11, MODE_S = 2'b01, MODE_N = 2'b00;

    always #2.5 clk = ~clk;

    irq_prio_sel u_irq_prio_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_pend   (pend),
        .irq_en     (en),
        .irq_deleg  (deleg),
        .m_en       (men),
        .s_en       (sen),
        .take_vld   (take_vld),
        .take_cause (take_cause),
        .take_mode  (take_mode)
    );

    task automatic chk(input string req, input bit ev, input int ec, input logic [1:0] em);
        n_run++;
        if (take_vld !== ev || take_cause !== 4'(ec) || take_mode !== em) begin
            n_fail++;
            $display("FAIL %s: got vld=%0b cause=%0d mode=%b, expected vld=%0b cause=%0d mode=%b",
                     req, take_vld, take_cause, take_mode, ev, ec, em);
        end
    endtask

    // Drive new inputs and move to 1 ns after the edge that registers them.
    task automatic apply(input logic [15:0] p, input logic [15:0] e, input logic [15:0] d,
                         input logic me, input logic se);
        pend = p; en = e; deleg = d; men = me; sen = se;
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        pend = ALL_IMPL; en = ALL_IMPL;
        @(posedge clk); @(posedge clk); #1;
        chk("R1 during reset", 0, 0, MODE_N);
        pend = '0; en = '0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 after reset", 0, 0, MODE_N);
    endtask

    task automatic t_single();
        int codes [7] = '{11, 3, 7, 9, 1, 5, 13};
        foreach (codes[i]) begin
            apply(16'(1) << codes[i], ALL_IMPL, '0, 1, 1);
            chk("R11 single source to M", 1, codes[i], MODE_M);
        end
    endtask

    task automatic t_m_order();
        int codes [7] = '{11, 3, 7, 9, 1, 5, 13};
        logic [15:0] p = ALL_IMPL;
        foreach (codes[i]) begin
            apply(p, ALL_IMPL, '0, 1, 1);
            chk("R4 machine rank", 1, codes[i], MODE_M);
            p[codes[i]] = 1'b0;
        end
        apply(p, ALL_IMPL, '0, 1, 1);
        chk("R4 none left", 0, 0, MODE_N);
    endtask

    task automatic t_s_order();
        int codes [4] = '{9, 1, 5, 13};
        logic [15:0] p = 16'h2222;
        foreach (codes[i]) begin
            apply(p, ALL_IMPL, 16'hFFFF, 1, 1);
            chk("R5 supervisor rank", 1, codes[i], MODE_S);
            p[codes[i]] = 1'b0;
        end
    endtask

    task automatic t_deleg_ignored();
        apply(16'h0080, ALL_IMPL, 16'hFFFF, 1, 1);
        chk("R6 cause 7 stays in M", 1, 7, MODE_M);
        apply(16'h0808, ALL_IMPL, 16'hFFFF, 1, 1);
        chk("R6 cause 11 stays in M", 1, 11, MODE_M);
    endtask

    task automatic t_cross();
        apply(16'h2200, ALL_IMPL, 16'h0200, 1, 1);
        chk("R3 undelegated overflow beats delegated SEI", 1, 13, MODE_M);
        apply(16'h2200, ALL_IMPL, 16'h2200, 1, 1);
        chk("R7 both delegated, SEI first", 1, 9, MODE_S);
        apply(16'h2000, ALL_IMPL, 16'h2000, 1, 1);
        chk("R7 overflow delegated to S", 1, 13, MODE_S);
    endtask

    task automatic t_gate();
        apply(ALL_IMPL, 16'h0000, '0, 1, 1);
        chk("R2 pending without enable", 0, 0, MODE_N);
        apply(16'h0000, ALL_IMPL, '0, 1, 1);
        chk("R2 enable without pending", 0, 0, MODE_N);
        apply(16'h0020, 16'h0022, '0, 1, 1);
        chk("R2 only matched bit wins", 1, 5, MODE_M);
    endtask

    task automatic t_unimpl();
        apply(16'hD555, 16'hFFFF, '0, 1, 1);
        chk("R8 unimplemented bits ignored", 0, 0, MODE_N);
    endtask

    task automatic t_global();
        apply(16'h0A00, ALL_IMPL, 16'h0200, 0, 1);
        chk("R9 m_en low leaves S path", 1, 9, MODE_S);
        apply(16'h0A00, ALL_IMPL, 16'h0200, 1, 0);
        chk("R9 s_en low leaves M path", 1, 11, MODE_M);
        apply(16'h0A00, ALL_IMPL, 16'h0200, 0, 0);
        chk("R9 both low", 0, 0, MODE_N);
    endtask

    task automatic t_latency();
        apply(16'h0008, ALL_IMPL, '0, 1, 1);
        chk("R10 settle", 1, 3, MODE_M);
        pend = 16'h0002; deleg = 16'h0002;
        #1;
        chk("R10 old value held before edge", 1, 3, MODE_M);
        @(posedge clk); #1;
        chk("R10 new value one edge later", 1, 1, MODE_S);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_m_order();
        t_s_order();
        t_deleg_ignored();
        t_cross();
        t_gate();
        t_unimpl();
        t_global();
        t_latency();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule